// File: doc/BRIEF.md
# Two-Read One-Write Register File with Write-Collision Policy

This block holds the architectural registers of a pipelined datapath. Two operand reads are served in the same cycle through combinational read ports, and one result is written per cycle on the rising clock edge. Each read port looks up its entry through an index and returns that entry's word with no clock delay.

A read port and the write port can address the same register in one cycle. A compile-time parameter decides what the read returns in that case. In pass-through mode the read returns the word being written. In hold mode it returns the contents from before the edge. Pass-through lets a writeback-stage result reach an operand read in the same cycle, so the pipeline needs no separate forward path from writeback. Hold mode keeps the read path shorter, but the pipeline must then forward from writeback itself. The two read ports resolve collisions each on its own.

Top module: `rf_2r1w`

## Requirements
- R1: A read port returns the stored word of the entry selected by its index in the same cycle, with no clock delay. With default parameters there are 32 entries of 32 bits and 5-bit indices.
- R2: When `wr_en_i` is 1 at a rising clock edge, entry `wr_idx_i` takes `wr_data_i`. The new word is visible on a non-colliding read from the next cycle on.
- R3: When `wr_en_i` is 0 at a rising edge, no entry changes, whatever `wr_idx_i` and `wr_data_i` hold.
- R4: With `POLICY` = `COLLIDE_NEW` (encoded 1, the default), a read whose index equals `wr_idx_i` while `wr_en_i` is 1 returns `wr_data_i` in that same cycle.
- R5: With `POLICY` = `COLLIDE_OLD` (encoded 0), such a colliding read returns the word stored before the edge.
- R6: An index match with `wr_en_i` at 0 is not a collision: the read returns the stored word.
- R7: Each port decides on collision separately. Both ports may return the incoming word in one cycle, and a port that does not collide returns its stored word while the other port collides.
- R8: Driving `rst_ni` low clears every entry to zero at once, without waiting for a clock edge.
- R9: A write changes only the addressed entry. Entry 0 is an ordinary writable register, and the highest index is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all entries |
| rd_idx_a_i | input | IDX_W | Index for read port A |
| rd_idx_b_i | input | IDX_W | Index for read port B |
| wr_idx_i | input | IDX_W | Index of the entry to write |
| wr_data_i | input | DATA_W | Word to write |
| wr_en_i | input | 1 | Write enable |
| rd_data_a_o | output | DATA_W | Word returned on read port A |
| rd_data_b_o | output | DATA_W | Word returned on read port B |

## Verification
A combinational read and a pending write can land on the same register in the same cycle. That case is provoked by driving a read index equal to the write index while the write is enabled, sometimes on one port and sometimes on both. Two instances, one per policy, receive the same stimulus. The outputs are sampled before the committing edge and compared with the incoming word for pass-through and with the earlier stored word for hold. The same index match is also driven with the write disabled, and entries are read again in later cycles, to confirm that no collision logic fires and that no write happened.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    COLLIDE_OLD = 1'b0,
    COLLIDE_NEW = 1'b1
  } collide_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  mem_o
);
  logic [NUM_REGS-1:0] wr_sel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    assign wr_sel[i] = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mem_o[i] <= '0;
      else if (wr_sel[i]) mem_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter int       DATA_W   = 32,
  parameter collide_e POLICY   = COLLIDE_NEW,
  localparam int      IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] mem_i,
  input  logic [IDX_W-1:0]                rd_idx_i,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [DATA_W-1:0]               rd_data_o
);
  logic [DATA_W-1:0] stored;
  assign stored = mem_i[rd_idx_i];

  if (POLICY == COLLIDE_NEW) begin : g_new
    logic hit;
    assign hit       = wr_en_i && (wr_idx_i == rd_idx_i);
    assign rd_data_o = hit ? wr_data_i : stored;
  end else begin : g_old
    logic             unused_wr;
    assign unused_wr = wr_en_i ^ (^wr_idx_i) ^ (^wr_data_i);
    assign rd_data_o = stored;
  end
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w
  import rf_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter int       DATA_W   = 32,
  parameter collide_e POLICY   = COLLIDE_NEW,
  localparam int      IDX_W    = $clog2(NUM_REGS),
  localparam int      NUM_RD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_a_i,
  input  logic [IDX_W-1:0]  rd_idx_b_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  output logic [DATA_W-1:0] rd_data_b_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  assign rd_idx[0]   = rd_idx_a_i;
  assign rd_idx[1]   = rd_idx_b_i;
  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  rf_storage #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .mem_o     (mem_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .POLICY   (POLICY)
    ) u_port (
      .mem_i     (mem_q),
      .rd_idx_i  (rd_idx[p]),
      .wr_en_i   (wr_en_i),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data[p])
    );
  end
endmodule

// File: rtl/rf_2r1w_chk.sv
module rf_2r1w_chk
  import rf_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter int       DATA_W   = 32,
  parameter collide_e POLICY   = COLLIDE_NEW,
  localparam int      IDX_W    = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [IDX_W-1:0]                rd_idx_a_i,
  input logic [IDX_W-1:0]                rd_idx_b_i,
  input logic [IDX_W-1:0]                wr_idx_i,
  input logic [DATA_W-1:0]               wr_data_i,
  input logic                            wr_en_i,
  input logic [DATA_W-1:0]               rd_data_a_o,
  input logic [DATA_W-1:0]               rd_data_b_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] mem_q
);
  logic hit_a, hit_b;
  assign hit_a = wr_en_i && (wr_idx_i == rd_idx_a_i);
  assign hit_b = wr_en_i && (wr_idx_i == rd_idx_b_i);

  p_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rst_ni) |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && rst_ni) |=> $stable(mem_q));

  p_pass_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_a |-> rd_data_a_o == mem_q[rd_idx_a_i]);

  p_pass_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_b |-> rd_data_b_o == mem_q[rd_idx_b_i]);

  if (POLICY == COLLIDE_NEW) begin : g_new
    p_new_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_a |-> rd_data_a_o == wr_data_i);
    p_new_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_b |-> rd_data_b_o == wr_data_i);
  end else begin : g_old
    p_old_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_a |-> rd_data_a_o == mem_q[rd_idx_a_i]);
    p_old_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_b |-> rd_data_b_o == mem_q[rd_idx_b_i]);
  end
endmodule

bind rf_2r1w rf_2r1w_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .POLICY   (POLICY)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_idx_a_i  (rd_idx_a_i),
  .rd_idx_b_i  (rd_idx_b_i),
  .wr_idx_i    (wr_idx_i),
  .wr_data_i   (wr_data_i),
  .wr_en_i     (wr_en_i),
  .rd_data_a_o (rd_data_a_o),
  .rd_data_b_o (rd_data_b_o),
  .mem_q       (mem_q)
);

// File: tb/sim_rf_2r1w.sv
module sim_rf_2r1w;
  import rf_pkg::*;

  localparam int NR = 32;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam int NV = 8;

  typedef struct packed {
    logic          we;
    logic [IW-1:0] wi;
    logic [DW-1:0] wd;
    logic [IW-1:0] ra;
    logic [IW-1:0] rb;
    logic [DW-1:0] na;  // expected A, pass-through instance
    logic [DW-1:0] nb;
    logic [DW-1:0] oa;  // expected A, hold instance
    logic [DW-1:0] ob;
  } vec_t;

  // Walked from the all-zero reset state; each row checked before its edge.
  localparam vec_t TBL [NV] = '{
    '{1'b1, 5'd3,  32'h1111_1111, 5'd3, 5'd4,  32'h1111_1111, 32'h0,         32'h0,         32'h0},
    '{1'b1, 5'd4,  32'h2222_2222, 5'd3, 5'd4,  32'h1111_1111, 32'h2222_2222, 32'h1111_1111, 32'h0},
    '{1'b1, 5'd7,  32'h7777_7777, 5'd7, 5'd7,  32'h7777_7777, 32'h7777_7777, 32'h0,         32'h0},
    '{1'b0, 5'd3,  32'hDEAD_BEEF, 5'd3, 5'd4,  32'h1111_1111, 32'h2222_2222, 32'h1111_1111, 32'h2222_2222},
    '{1'b0, 5'd5,  32'h0,         5'd3, 5'd7,  32'h1111_1111, 32'h7777_7777, 32'h1111_1111, 32'h7777_7777},
    '{1'b1, 5'd3,  32'h3333_3333, 5'd3, 5'd7,  32'h3333_3333, 32'h7777_7777, 32'h1111_1111, 32'h7777_7777},
    '{1'b1, 5'd31, 32'hABCD_0123, 5'd0, 5'd31, 32'h0,         32'hABCD_0123, 32'h0,         32'h0},
    '{1'b0, 5'd0,  32'h5555_5555, 5'd31, 5'd3, 32'hABCD_0123, 32'h3333_3333, 32'hABCD_0123, 32'h3333_3333}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] rd_idx_a_i = '0, rd_idx_b_i = '0, wr_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] n_a, n_b, o_a, o_b;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rf_2r1w #(.NUM_REGS(NR), .DATA_W(DW), .POLICY(COLLIDE_NEW)) u0 (
    .clk_i, .rst_ni, .rd_idx_a_i, .rd_idx_b_i, .wr_idx_i, .wr_data_i, .wr_en_i,
    .rd_data_a_o(n_a), .rd_data_b_o(n_b));

  rf_2r1w #(.NUM_REGS(NR), .DATA_W(DW), .POLICY(COLLIDE_OLD)) u1 (
    .clk_i, .rst_ni, .rd_idx_a_i, .rd_idx_b_i, .wr_idx_i, .wr_data_i, .wr_en_i,
    .rd_data_a_o(o_a), .rd_data_b_o(o_b));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [IW-1:0] wi, input logic [DW-1:0] wd,
                       input logic [IW-1:0] ra, input logic [IW-1:0] rb);
    @(negedge clk_i);
    wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    rd_idx_a_i = ra; rd_idx_b_i = rb;
    #2;
  endtask

  initial begin
    // R8: reset state, R1 combinational read of entries 0 and 31
    #1;
    rd_idx_a_i = 5'd0; rd_idx_b_i = 5'd31;
    #1;
    chk("R8 reset new A", n_a, '0);
    chk("R8 reset new B", n_b, '0);
    chk("R8 reset old A", o_a, '0);
    chk("R8 reset old B", o_b, '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1..R7, R9 via the vector table
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].we, TBL[i].wi, TBL[i].wd, TBL[i].ra, TBL[i].rb);
      chk($sformatf("R4/R7 row%0d new A", i), n_a, TBL[i].na);
      chk($sformatf("R4/R7 row%0d new B", i), n_b, TBL[i].nb);
      chk($sformatf("R5/R6 row%0d old A", i), o_a, TBL[i].oa);
      chk($sformatf("R5/R6 row%0d old B", i), o_b, TBL[i].ob);
    end

    // R3: rows 3, 4 and 7 wrote nothing; entries 5 and 0 must still be zero
    drive(1'b0, 5'd0, 32'h0, 5'd5, 5'd0);
    chk("R3 entry5 untouched", n_a, '0);
    chk("R3/R9 entry0 untouched", o_b, '0);

    // R2: row 5 committed entry 3 on its edge in both instances
    drive(1'b0, 5'd0, 32'h0, 5'd3, 5'd4);
    chk("R2 commit old A", o_a, 32'h3333_3333);
    chk("R2 commit old B", o_b, 32'h2222_2222);

    // R9: entry 0 is writable, neighbour 1 stays zero
    drive(1'b1, 5'd0, 32'h0F0F_0F0F, 5'd1, 5'd2);
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd1);
    chk("R9 entry0 written", o_a, 32'h0F0F_0F0F);
    chk("R9 entry1 untouched", o_b, '0);

    // R7: only port B collides
    drive(1'b1, 5'd9, 32'h9999_0000, 5'd0, 5'd9);
    chk("R7 new A no hit", n_a, 32'h0F0F_0F0F);
    chk("R7 new B hit", n_b, 32'h9999_0000);
    chk("R7 old B hit", o_b, '0);

    // R8: asynchronous clear mid-run, checked before any edge
    drive(1'b0, 5'd0, 32'h0, 5'd3, 5'd31);
    rst_ni = 1'b0;
    #1;
    chk("R8 async clear new A", n_a, '0);
    chk("R8 async clear new B", n_b, '0);
    chk("R8 async clear old A", o_a, '0);
    chk("R8 async clear old B", o_b, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule